// File: doc/BRIEF.md
# Structured-Sparse Dot-Product Unit

This unit accumulates a dot product between a compressed weight stream and a dense activation vector. The weights follow a two-of-four structured pattern. Every four dense positions are carried as one group holding two stored signed weights, each paired with a 2-bit position code. The unit uses each code to pick one of the four activations in the matching four-element activation slice. It multiplies the two selected pairs and adds both products to a running sum. A plain dense design would need four multipliers per group. This one needs two.

Groups arrive one per beat on a valid/ready handshake. A flag marks the final group of a vector. One cycle after that final group is accepted, the total appears on a result port together with a valid. The result stays there until the consumer takes it. While a result is waiting, the input stalls. The first group accepted after a result starts a new sum.

Top module: `sparse_dot_unit`

## Requirements
- R1: Stored weight j (j = 0, 1) sits at `wVals[8j+7:8j]`, and its position code sits at `wIdxs[2j+1:2j]`. Code value k selects activation lane k, which is `actSlice[8k+7:8k]`. Weight j is multiplied only by the lane its code selects.
- R2: Weights and activations are 8-bit signed two's complement. Each product is sign-extended before it is added to a 24-bit signed accumulator, so negative and extreme operands (-128 × -128, -1 × 127) give the exact signed sum.
- R3: When both position codes in a group are equal, both products are still added. A zero weight therefore acts as padding.
- R4: The result is the sum of the two products of every group accepted since the previous result was taken, or since reset.
- R5: `resValid` rises in the cycle after a group with `grpLast` high is accepted. It stays high, with `resData` unchanged, until a cycle where `resReady` is high.
- R6: `grpReady` is low whenever `resValid` is high. Groups presented during that time are not consumed and do not change the next result.
- R7: The first group accepted after a result has been taken starts a fresh sum. No part of the previous total carries over.
- R8: A group is consumed only in a cycle where `grpValid` and `grpReady` are both high. Input changes while `grpValid` is low have no effect on `resData` or on the next result.
- R9: A synchronous active-high reset clears the accumulator, giving `resData` = 0 and `resValid` = 0, and leaves `grpReady` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grpValid | input | 1 | A group is present on the inputs |
| grpReady | output | 1 | The unit can accept a group this cycle |
| grpLast | input | 1 | This group is the final group of the vector |
| wVals | input | 16 | Two stored signed weights, weight j at bits 8j+7:8j |
| wIdxs | input | 4 | Two position codes, code j at bits 2j+1:2j |
| actSlice | input | 32 | Four signed activations, lane k at bits 8k+7:8k |
| resValid | output | 1 | The result is available |
| resReady | input | 1 | The consumer takes the result |
| resData | output | 24 | Signed dot-product result |

## Verification
The bench looks for the cases where the steering or the arithmetic could go quietly wrong.

- **Swapped code order, or codes pointing at the highest lane.** A lane multiplexer with a bad index would multiply the wrong activation.
- **Extreme signed operands.** A missing sign extension would turn small negative totals into large positive ones.
- **Equal codes in one group.** A design that treats the repeated position as a duplicate would drop one product.
- **Groups held on the input while a result waits, and input activity with valid low.** A design that consumes these would leak their products into the next sum.
- **The group right after a result.** Without a proper clear, that group would add onto the stale total.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
  localparam int DATA_W = 8;
  localparam int ACC_W = 24;
  localparam int GROUP_SIZE = 4;
  localparam int NNZ = 2;

  typedef struct packed {
    logic accept;
    logic clear;
    logic finish;
  } sduStrobes_t;
endpackage

// File: rtl/sdu_ctrl.sv
module sdu_ctrl (
  input  logic                clk,
  input  logic                rst,
  input  logic                grpValid,
  input  logic                grpLast,
  input  logic                resReady,
  output logic                grpReady,
  output logic                resValid,
  output sdu_pkg::sduStrobes_t strobes
);
  logic resValidQ;
  logic freshSum;
  logic accept;

  assign grpReady = !resValidQ;
  assign accept   = grpValid && grpReady;
  assign resValid = resValidQ;

  always_comb begin
    strobes.accept = accept;
    strobes.clear  = freshSum;
    strobes.finish = accept && grpLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValidQ <= 1'b0;
      freshSum  <= 1'b1;
    end else begin
      if (accept && grpLast) begin
        resValidQ <= 1'b1;
      end else if (resReady) begin
        resValidQ <= 1'b0;
      end
      if (accept) begin
        freshSum <= grpLast;
      end
    end
  end
endmodule

// File: rtl/sdu_datapath.sv
module sdu_datapath #(
  parameter int DATA_W     = sdu_pkg::DATA_W,
  parameter int ACC_W      = sdu_pkg::ACC_W,
  parameter int GROUP_SIZE = sdu_pkg::GROUP_SIZE,
  parameter int NNZ        = sdu_pkg::NNZ,
  localparam int IDX_W     = $clog2(GROUP_SIZE),
  localparam int PROD_W    = 2 * DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  sdu_pkg::sduStrobes_t         strobes,
  input  logic [NNZ*DATA_W-1:0]        wVals,
  input  logic [NNZ*IDX_W-1:0]         wIdxs,
  input  logic [GROUP_SIZE*DATA_W-1:0] actSlice,
  output logic [ACC_W-1:0]             accOut
);
  logic signed [ACC_W-1:0] prodExt [NNZ];
  logic signed [ACC_W-1:0] groupSum;
  logic signed [ACC_W-1:0] accQ;

  for (genvar j = 0; j < NNZ; j++) begin : g_lane
    logic [IDX_W-1:0]         laneIdx;
    logic signed [DATA_W-1:0] weight;
    logic signed [DATA_W-1:0] actSel;
    logic signed [PROD_W-1:0] prod;

    assign laneIdx    = wIdxs[j*IDX_W +: IDX_W];
    assign weight     = wVals[j*DATA_W +: DATA_W];
    assign actSel     = actSlice[laneIdx*DATA_W +: DATA_W];
    assign prod       = weight * actSel;
    assign prodExt[j] = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_comb begin
    groupSum = '0;
    for (int j = 0; j < NNZ; j++) begin
      groupSum = groupSum + prodExt[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
    end else if (strobes.accept) begin
      accQ <= (strobes.clear ? '0 : accQ) + groupSum;
    end
  end

  assign accOut = accQ;
endmodule

// File: rtl/sparse_dot_unit.sv
module sparse_dot_unit #(
  parameter int DATA_W     = sdu_pkg::DATA_W,
  parameter int ACC_W      = sdu_pkg::ACC_W,
  parameter int GROUP_SIZE = sdu_pkg::GROUP_SIZE,
  parameter int NNZ        = sdu_pkg::NNZ,
  localparam int IDX_W     = $clog2(GROUP_SIZE)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         grpValid,
  output logic                         grpReady,
  input  logic                         grpLast,
  input  logic [NNZ*DATA_W-1:0]        wVals,
  input  logic [NNZ*IDX_W-1:0]         wIdxs,
  input  logic [GROUP_SIZE*DATA_W-1:0] actSlice,
  output logic                         resValid,
  input  logic                         resReady,
  output logic [ACC_W-1:0]             resData
);
  sdu_pkg::sduStrobes_t strobes;

  sdu_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .grpValid (grpValid),
    .grpLast  (grpLast),
    .resReady (resReady),
    .grpReady (grpReady),
    .resValid (resValid),
    .strobes  (strobes)
  );

  sdu_datapath #(
    .DATA_W     (DATA_W),
    .ACC_W      (ACC_W),
    .GROUP_SIZE (GROUP_SIZE),
    .NNZ        (NNZ)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wVals    (wVals),
    .wIdxs    (wIdxs),
    .actSlice (actSlice),
    .accOut   (resData)
  );
endmodule

// File: rtl/sdu_checker.sv
module sdu_checker #(
  parameter int ACC_W = sdu_pkg::ACC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             grpValid,
  input logic             grpReady,
  input logic             grpLast,
  input logic             resValid,
  input logic             resReady,
  input logic [ACC_W-1:0] resData
);
  p_ready_low_r6: assert property (@(posedge clk) disable iff (rst)
    resValid |-> !grpReady);

  p_valid_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    (grpValid && grpReady && grpLast) |=> resValid);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |=> (resValid && $stable(resData)));

  p_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(resValid) |-> $past(grpValid && grpReady && grpLast));

  p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !(grpValid && grpReady) |=> $stable(resData));
endmodule

bind sparse_dot_unit sdu_checker #(.ACC_W(ACC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .grpValid (grpValid),
  .grpReady (grpReady),
  .grpLast  (grpLast),
  .resValid (resValid),
  .resReady (resReady),
  .resData  (resData)
);

// File: tb/sparse_dot_unit_tb_top.sv
module sparse_dot_unit_tb_top;
  typedef struct packed {
    logic [7:0]  w0;
    logic [7:0]  w1;
    logic [1:0]  i0;
    logic [1:0]  i1;
    logic [31:0] act;
    logic        last;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h03, 8'hFE, 2'd1, 2'd3, 32'h04050607, 1'b0},
    '{8'h80, 8'h7F, 2'd0, 2'd2, 32'h11228080, 1'b1},
    '{8'h05, 8'h00, 2'd2, 2'd2, 32'h00F60000, 1'b0},
    '{8'hFF, 8'h01, 2'd3, 2'd0, 32'h7F000081, 1'b1},
    '{8'h10, 8'h20, 2'd0, 2'd1, 32'h00000201, 1'b1},
    '{8'h80, 8'h80, 2'd3, 2'd3, 32'h80000000, 1'b0},
    '{8'h7F, 8'hC0, 2'd2, 2'd1, 32'h0A7F9C05, 1'b0},
    '{8'hF0, 8'h0E, 2'd1, 2'd0, 32'h3355E1C8, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        grpValid;
  logic        grpReady;
  logic        grpLast;
  logic [15:0] wVals;
  logic [3:0]  wIdxs;
  logic [31:0] actSlice;
  logic        resValid;
  logic        resReady;
  logic [23:0] resData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sparse_dot_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .grpValid (grpValid),
    .grpReady (grpReady),
    .grpLast  (grpLast),
    .wVals    (wVals),
    .wIdxs    (wIdxs),
    .actSlice (actSlice),
    .resValid (resValid),
    .resReady (resReady),
    .resData  (resData)
  );

  function automatic int laneOf(input logic [31:0] act, input logic [1:0] k);
    logic [7:0] b;
    b = 8'(act >> (8 * k));
    return int'($signed(b));
  endfunction

  function automatic int modelGroup(input vec_t v);
    return int'($signed(v.w0)) * laneOf(v.act, v.i0)
         + int'($signed(v.w1)) * laneOf(v.act, v.i1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendGroup(input vec_t v);
    @(negedge clk);
    while (!grpReady) @(negedge clk);
    grpValid = 1'b1;
    wVals    = {v.w1, v.w0};
    wIdxs    = {v.i1, v.i0};
    actSlice = v.act;
    grpLast  = v.last;
    @(posedge clk);
    @(negedge clk);
    grpValid = 1'b0;
    grpLast  = 1'b0;
  endtask

  task automatic checkResult(input int exp, input string req);
    check(resValid === 1'b1, {req, " valid"}, int'(resValid), 1);
    check(int'($signed(resData)) == exp, req, int'($signed(resData)), exp);
  endtask

  task automatic takeResult();
    resReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resReady = 1'b0;
    check(resValid === 1'b0, "R5 drop after take", int'(resValid), 0);
  endtask

  initial begin
    int expSum;
    vec_t g;
    rst = 1'b1; grpValid = 1'b0; grpLast = 1'b0; resReady = 1'b0;
    wVals = '0; wIdxs = '0; actSlice = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(resValid === 1'b0, "R9 resValid", int'(resValid), 0);
    check(grpReady === 1'b1, "R9 grpReady", int'(grpReady), 1);
    check(resData === 24'd0, "R9 resData", int'(resData), 0);

    // R1 R2 R3 R4 R7: table walk
    expSum = 0;
    for (int n = 0; n < NV; n++) begin
      sendGroup(VEC[n]);
      expSum += modelGroup(VEC[n]);
      if (VEC[n].last) begin
        checkResult(expSum, "R1/R2/R3/R4 table");
        takeResult();
        expSum = 0;
      end
    end

    // R5 R6: hold result while groups are presented
    g = '{8'h02, 8'h03, 2'd0, 2'd3, 32'h05000004, 1'b1};
    sendGroup(g);
    expSum = modelGroup(g);
    @(negedge clk);
    grpValid = 1'b1; grpLast = 1'b0;
    wVals = 16'h7F7F; wIdxs = 4'h0; actSlice = 32'h7F7F7F7F;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      check(grpReady === 1'b0, "R6 ready low", int'(grpReady), 0);
      checkResult(expSum, "R5 hold");
    end
    grpValid = 1'b0;
    takeResult();

    // R8: activity with valid low, then one group
    @(negedge clk);
    wVals = 16'h8080; wIdxs = 4'hF; actSlice = 32'h80808080; grpLast = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(resValid === 1'b0, "R8 no result", int'(resValid), 0);
    g = '{8'hFD, 8'h00, 2'd1, 2'd1, 32'h00000900, 1'b1};
    sendGroup(g);
    checkResult(modelGroup(g), "R6/R7/R8 fresh sum");
    takeResult();

    // R9: reset mid-accumulation
    g = '{8'h40, 8'h40, 2'd2, 2'd3, 32'h40400000, 1'b0};
    sendGroup(g);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(resData === 24'd0, "R9 mid reset", int'(resData), 0);
    g.last = 1'b1;
    sendGroup(g);
    checkResult(modelGroup(g), "R9 after reset");
    takeResult();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule